// File: doc/BRIEF.md
# Flash Protected Range Checker

This block screens every flash access that a cycle engine is about to start. It holds a bank of five protection windows over a 25-bit flash address space. Each window has two limits at 4 KiB granularity. The lower limit covers the first byte of its 4 KiB page and the upper limit covers the last byte of its page. Each window also has two independent enables, one for reads and one for writes. The write enable also covers erase operations.

The cycle engine presents an address, a flag that marks the access as a write or erase, and a one-cycle check strobe. One clock later the checker returns a valid pulse and a deny flag. The deny flag is the OR of all windows. When deny is set, the engine reports an error instead of driving the bus.

Firmware programs the windows through a simple indexed write port, and the windows can be read back. The windows have no effect until a lock-down request arrives. From that point until reset, the windows are both enforced and frozen.

Top module: `prg_guard`

## Requirements
- R1: After reset every window word reads 0, `locked` is 0 and `res_valid` and `res_deny` are 0.
- R2: While unlocked, a write with `cfg_we`=1 to index 0..4 stores the word. Bit 31 is the write/erase enable, bit 15 is the read enable, bits 28:16 are the upper-limit page (address bits 24:12) and bits 12:0 are the lower-limit page. Bits 30:29 and 14:13 always read as 0.
- R3: A write to an index of 5 or more changes no window, and reading such an index returns 0.
- R4: While `locked` is 0, no check is denied, whatever the window contents.
- R5: A one-cycle `lock_req` sets `locked`. It stays set until reset, and while it is set, writes to the windows are ignored.
- R6: Once locked, a write check is denied when the address lies in [lower_page*4096, upper_page*4096+4095] inclusive of any window whose write enable is set. Addresses one below and one above that interval are allowed.
- R7: The two enables are separate. A read check is denied only by the read enable, and a write check only by the write enable.
- R8: `res_valid` is high in exactly the cycle after a cycle with `chk_valid` high. `res_deny` is never high without `res_valid`.
- R9: Deny is the OR over all five windows. A window whose lower page exceeds its upper page matches no address, and the top page (0x1FFF) covers address 0x1FFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Window write strobe |
| cfg_idx | input | 3 | Window index for write and read-back |
| cfg_wdata | input | 32 | Window word to write |
| cfg_rdata | output | 32 | Window word at `cfg_idx` (0 for unused indices) |
| lock_req | input | 1 | Lock-down request, sticky until reset |
| locked | output | 1 | Lock-down state |
| chk_valid | input | 1 | Check strobe for one access |
| chk_addr | input | 25 | Flash byte address of the access |
| chk_is_write | input | 1 | 1 for write or erase, 0 for read |
| res_valid | output | 1 | Result valid, one cycle after `chk_valid` |
| res_deny | output | 1 | Access blocked |

## Verification
Accesses are placed exactly on both inclusive limits of a window and one byte outside each limit. This separates a correct page padding from one that is off by one or that uses the wrong fill value. The same addresses are probed as both reads and writes against windows that have only one enable set, which catches enables that are crossed or merged. A window with inverted limits and a window at the top page test the empty-window and top-of-space cases. The same in-range access is repeated before locking, after locking and after an attempted overwrite under lock. This shows that enforcement waits for the lock and that the frozen contents are what get enforced.

// File: rtl/prg_pkg.sv
package prg_pkg;
  localparam int FLASH_AW = 25;
  localparam int PAGE_W   = 12;
  localparam int LIM_W    = FLASH_AW - PAGE_W;
  localparam int REG_W    = 32;
  localparam int WP_BIT   = 31;
  localparam int RP_BIT   = 15;
  localparam int HI_LSB   = 16;
  localparam int LO_LSB   = 0;

  localparam logic [REG_W-1:0] LIM_ONES  = (REG_W'(1) << LIM_W) - REG_W'(1);
  localparam logic [REG_W-1:0] KEEP_MASK = (REG_W'(1) << WP_BIT) |
                                           (REG_W'(1) << RP_BIT) |
                                           (LIM_ONES << HI_LSB)  |
                                           (LIM_ONES << LO_LSB);

  typedef struct packed {
    logic             wr_en;
    logic             rd_en;
    logic [LIM_W-1:0] hi_pg;
    logic [LIM_W-1:0] lo_pg;
  } win_t;

  function automatic win_t word_to_win(input logic [REG_W-1:0] w);
    win_t r;
    r.wr_en = w[WP_BIT];
    r.rd_en = w[RP_BIT];
    r.hi_pg = w[HI_LSB +: LIM_W];
    r.lo_pg = w[LO_LSB +: LIM_W];
    return r;
  endfunction
endpackage

// File: rtl/prg_rst_sync.sv
module prg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      out_q  <= meta_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/prg_regfile.sv
module prg_regfile #(
  parameter int NUM_RANGES = 5,
  parameter int IDX_W      = 3,
  parameter int REG_W      = prg_pkg::REG_W
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfg_we,
  input  logic [IDX_W-1:0]                 cfg_idx,
  input  logic [REG_W-1:0]                 cfg_wdata,
  output logic [REG_W-1:0]                 cfg_rdata,
  input  logic                             lock_req,
  output logic                             lock_o,
  output logic [NUM_RANGES-1:0][REG_W-1:0] words_o
);
  import prg_pkg::*;

  logic [NUM_RANGES-1:0][REG_W-1:0] word_q;
  logic [NUM_RANGES-1:0][REG_W-1:0] word_d;
  logic                             lock_q;
  logic                             lock_d;
  logic                             idx_ok;

  assign idx_ok = (int'(cfg_idx) < NUM_RANGES);

  always_comb begin
    lock_d = lock_q | lock_req;
  end

  for (genvar i = 0; i < NUM_RANGES; i++) begin : g_word
    logic sel;
    assign sel = cfg_we && !lock_q && (int'(cfg_idx) == i);

    always_comb begin
      word_d[i] = word_q[i];
      if (sel) word_d[i] = cfg_wdata & KEEP_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q[i] <= '0;
      else if (sel) word_q[i] <= word_d[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b0;
    else        lock_q <= lock_d;
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NUM_RANGES; i++) begin
      if (idx_ok && int'(cfg_idx) == i) cfg_rdata = word_q[i];
    end
  end

  assign lock_o  = lock_q;
  assign words_o = word_q;

  p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(word_q));
  p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  p_oob_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !idx_ok) |=> $stable(word_q));
endmodule

// File: rtl/prg_range_cmp.sv
module prg_range_cmp #(
  parameter int FLASH_AW = prg_pkg::FLASH_AW,
  parameter int PAGE_W   = prg_pkg::PAGE_W,
  parameter int REG_W    = prg_pkg::REG_W
) (
  input  logic [REG_W-1:0]    word_i,
  input  logic [FLASH_AW-1:0] addr_i,
  input  logic                is_write_i,
  output logic                hit_o
);
  import prg_pkg::*;

  win_t              win;
  logic [FLASH_AW-1:0] lo_addr;
  logic [FLASH_AW-1:0] hi_addr;
  logic              in_win;
  logic              kind_en;

  always_comb begin
    win     = word_to_win(word_i);
    lo_addr = {win.lo_pg, {PAGE_W{1'b0}}};
    hi_addr = {win.hi_pg, {PAGE_W{1'b1}}};
    in_win  = (addr_i >= lo_addr) && (addr_i <= hi_addr);
    kind_en = is_write_i ? win.wr_en : win.rd_en;
    hit_o   = in_win && kind_en;
  end
endmodule

// File: rtl/prg_result.sv
module prg_result #(
  parameter int NUM_RANGES = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  chk_valid,
  input  logic                  enforce,
  input  logic [NUM_RANGES-1:0] hits,
  output logic                  res_valid,
  output logic                  res_deny
);
  logic valid_d, valid_q;
  logic deny_d,  deny_q;

  always_comb begin
    valid_d = chk_valid;
    deny_d  = chk_valid && enforce && (|hits);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      deny_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      deny_q  <= deny_d;
    end
  end

  assign res_valid = valid_q;
  assign res_deny  = deny_q;
endmodule

// File: rtl/prg_guard.sv
module prg_guard #(
  parameter int NUM_RANGES = 5,
  parameter int IDX_W      = 3,
  parameter int FLASH_AW   = prg_pkg::FLASH_AW,
  parameter int REG_W      = prg_pkg::REG_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [IDX_W-1:0]    cfg_idx,
  input  logic [REG_W-1:0]    cfg_wdata,
  output logic [REG_W-1:0]    cfg_rdata,
  input  logic                lock_req,
  output logic                locked,
  input  logic                chk_valid,
  input  logic [FLASH_AW-1:0] chk_addr,
  input  logic                chk_is_write,
  output logic                res_valid,
  output logic                res_deny
);
  logic                             rst_int_n;
  logic [NUM_RANGES-1:0][REG_W-1:0] words;
  logic [NUM_RANGES-1:0]            hits;

  prg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  prg_regfile #(.NUM_RANGES(NUM_RANGES), .IDX_W(IDX_W), .REG_W(REG_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cfg_we    (cfg_we),
    .cfg_idx   (cfg_idx),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .lock_req  (lock_req),
    .lock_o    (locked),
    .words_o   (words)
  );

  for (genvar i = 0; i < NUM_RANGES; i++) begin : g_cmp
    prg_range_cmp #(.FLASH_AW(FLASH_AW), .REG_W(REG_W)) u_cmp (
      .word_i     (words[i]),
      .addr_i     (chk_addr),
      .is_write_i (chk_is_write),
      .hit_o      (hits[i])
    );
  end

  prg_result #(.NUM_RANGES(NUM_RANGES)) u_res (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .chk_valid (chk_valid),
    .enforce   (locked),
    .hits      (hits),
    .res_valid (res_valid),
    .res_deny  (res_deny)
  );

  p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    chk_valid |=> res_valid);
  p_valid_idle_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    !chk_valid |=> !res_valid);
  p_deny_qualified_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    res_deny |-> res_valid);
  p_no_deny_unlocked_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    !locked |=> !res_deny);
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cfg_rdata[30:29] == 2'b00) && (cfg_rdata[14:13] == 2'b00));
endmodule

// File: tb/prg_guard_tb.sv
module prg_guard_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_idx;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        lock_req;
  logic        locked;
  logic        chk_valid;
  logic [24:0] chk_addr;
  logic        chk_is_write;
  logic        res_valid;
  logic        res_deny;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  prg_guard u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lock_req(lock_req),
    .locked(locked), .chk_valid(chk_valid), .chk_addr(chk_addr),
    .chk_is_write(chk_is_write), .res_valid(res_valid), .res_deny(res_deny)
  );

  task automatic expect_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr_win(input logic [2:0] idx, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_win(input string tag, input logic [2:0] idx, input logic [31:0] exp);
    @(negedge clk);
    cfg_idx = idx;
    #1;
    expect_eq(tag, cfg_rdata, exp);
  endtask

  task automatic probe(input string tag, input logic [24:0] addr, input logic wr, input logic exp_deny);
    @(negedge clk);
    chk_valid = 1'b1; chk_addr = addr; chk_is_write = wr;
    @(negedge clk);
    chk_valid = 1'b0; chk_addr = '0;
    expect_eq({tag, " valid"}, {31'd0, res_valid}, 32'd1);
    expect_eq({tag, " deny"}, {31'd0, res_deny}, {31'd0, exp_deny});
  endtask

  task automatic t_reset_state();
    expect_eq("R1 res_valid", {31'd0, res_valid}, 0);
    expect_eq("R1 res_deny", {31'd0, res_deny}, 0);
    expect_eq("R1 locked", {31'd0, locked}, 0);
    for (int i = 0; i < 5; i++) rd_win("R1 word", 3'(i), 32'h0);
  endtask

  task automatic t_program();
    wr_win(3'd1, 32'hFFFF_FFFF);
    rd_win("R2 reserved bits masked", 3'd1, 32'h9FFF_9FFF);
    wr_win(3'd0, 32'h801F_0010);
    rd_win("R2 window 0", 3'd0, 32'h801F_0010);
    wr_win(3'd1, 32'h0100_8100);
    rd_win("R2 window 1 rewrite", 3'd1, 32'h0100_8100);
    wr_win(3'd2, 32'h8040_8050);
    wr_win(3'd4, 32'h9FFF_1FFF);
    rd_win("R2 window 4", 3'd4, 32'h9FFF_1FFF);
  endtask

  task automatic t_bad_index();
    wr_win(3'd5, 32'h8001_0000);
    wr_win(3'd7, 32'h8001_0000);
    rd_win("R3 index 5 reads 0", 3'd5, 32'h0);
    rd_win("R3 index 7 reads 0", 3'd7, 32'h0);
    rd_win("R3 window 3 untouched", 3'd3, 32'h0);
    rd_win("R3 window 0 untouched", 3'd0, 32'h801F_0010);
  endtask

  task automatic t_unlocked();
    probe("R4 write in window 0 unlocked", 25'h010000, 1'b1, 1'b0);
    probe("R4 read in window 1 unlocked", 25'h100000, 1'b0, 1'b0);
  endtask

  task automatic t_lock();
    @(negedge clk);
    lock_req = 1'b1;
    @(negedge clk);
    lock_req = 1'b0;
    repeat (3) @(negedge clk);
    expect_eq("R5 locked sticky", {31'd0, locked}, 1);
  endtask

  task automatic t_bounds();
    probe("R6 lower bound", 25'h010000, 1'b1, 1'b1);
    probe("R6 below lower", 25'h00FFFF, 1'b1, 1'b0);
    probe("R6 upper bound", 25'h01FFFF, 1'b1, 1'b1);
    probe("R6 above upper", 25'h020000, 1'b1, 1'b0);
  endtask

  task automatic t_kinds();
    probe("R7 read in write-only window", 25'h015000, 1'b0, 1'b0);
    probe("R7 write in read-only window", 25'h100000, 1'b1, 1'b0);
    probe("R7 read in read-only window top", 25'h100FFF, 1'b0, 1'b1);
    probe("R7 read past read-only window", 25'h101000, 1'b0, 1'b0);
  endtask

  task automatic t_or_and_edges();
    probe("R9 inverted window write", 25'h045000, 1'b1, 1'b0);
    probe("R9 inverted window read", 25'h045000, 1'b0, 1'b0);
    probe("R9 top address write", 25'h1FFFFFF, 1'b1, 1'b1);
    probe("R9 top page first byte", 25'h1FFF000, 1'b1, 1'b1);
    probe("R9 top address read", 25'h1FFFFFF, 1'b0, 1'b0);
  endtask

  task automatic t_frozen();
    wr_win(3'd0, 32'h0000_0000);
    rd_win("R5 window 0 frozen", 3'd0, 32'h801F_0010);
    probe("R5 frozen window still enforced", 25'h010000, 1'b1, 1'b1);
  endtask

  task automatic t_valid_timing();
    @(negedge clk);
    chk_valid = 1'b1; chk_addr = 25'h010000; chk_is_write = 1'b1;
    #1;
    expect_eq("R8 no result same cycle", {31'd0, res_valid}, 0);
    @(negedge clk);
    chk_valid = 1'b0;
    expect_eq("R8 result next cycle", {31'd0, res_valid}, 1);
    expect_eq("R8 deny with result", {31'd0, res_deny}, 1);
    @(negedge clk);
    expect_eq("R8 valid drops", {31'd0, res_valid}, 0);
    expect_eq("R8 deny drops", {31'd0, res_deny}, 0);
  endtask

  task automatic t_reset_again();
    do_reset();
    expect_eq("R1 unlocked after reset", {31'd0, locked}, 0);
    rd_win("R1 window 0 cleared", 3'd0, 32'h0);
    probe("R1 no deny after reset", 25'h010000, 1'b1, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_wdata = '0;
    lock_req = 1'b0; chk_valid = 1'b0; chk_addr = '0; chk_is_write = 1'b0;
    do_reset();
    t_reset_state();
    t_program();
    t_bad_index();
    t_unlocked();
    t_lock();
    t_bounds();
    t_kinds();
    t_or_and_edges();
    t_frozen();
    t_valid_timing();
    t_reset_again();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule